// File: doc/BRIEF.md
# Time-of-day aligned waveform generator

This block drives a set of output pins from the nanosecond part of a time-of-day counter. Each pin has its own settings: an action (idle or clock), a sync flag, and two 30-bit nanosecond durations, one for high time and one for low time. The time counter is outside the block. Its nanosecond value, which wraps from 999 999 999 to 0, comes in on an input. Durations are counted in steps of `TICK_NS`, the amount that counter advances on each clock edge.

When the sync flag is clear, clock mode runs. The pin goes high as soon as the mode becomes valid and then alternates between the high and low durations. When the sync flag is set, the low-duration value becomes a phase offset within each second. A pulse of the high duration starts whenever the time-of-day reaches or passes that offset, including across the rollover from one second to the next. If the selected mode has settings out of range, the pin is held low, and the idle action always holds it low. Several instances sit side by side in a generate loop, one per pin.

Top module: `wfg_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every `pin_out` bit is 0.
- R2: With `cfg_act[i]` = 0 (idle), `pin_out[i]` is 0 on the next clock, whatever the durations, the sync flag or the time-of-day.
- R3: With `cfg_act[i]` = 1 and `cfg_sync[i]` = 0, `pin_out[i]` becomes 1 on the clock after the mode becomes valid. It then stays high for ceil(high/TICK_NS) cycles and low for ceil(low/TICK_NS) cycles, alternating.
- R4: In clock mode, a high or low duration of 6 or less keeps `pin_out[i]` at 0. A duration of 7 is accepted.
- R5: With `cfg_act[i]` = 1 and `cfg_sync[i]` = 1, `pin_out[i]` becomes 1 on the clock after the one where `tod_ns` first equals the phase in `low_ns[i]`.
- R6: In sync mode, a pulse also starts if `tod_ns` steps from below the phase to above it in one clock.
- R7: In sync mode, a pulse starts when `tod_ns` wraps from the end of a second back to a value at or beyond the phase, for example a phase of 0.
- R8: A sync pulse lasts ceil(high/TICK_NS) cycles. The pin then stays low until the next crossing of the phase.
- R9: In sync mode, a phase of 1 000 000 000 or more, a high duration of 6 or less, or a high duration of one second or more keeps `pin_out[i]` at 0.
- R10: Each pin follows only its own settings. Pins in different modes run at the same time without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time-of-day advances once per edge |
| rst | input | 1 | Synchronous active-high reset |
| tod_ns | input | 30 | Nanosecond part of the time-of-day, 0 to 999 999 999 |
| cfg_act | input | N_CH | Per-pin action: 0 idle, 1 clock |
| cfg_sync | input | N_CH | Per-pin sync flag: 1 selects pulse-per-second alignment |
| high_ns | input | N_CH x 30 | Per-pin high duration in ns |
| low_ns | input | N_CH x 30 | Per-pin low duration in ns (clock mode) or phase in ns (sync mode) |
| pin_out | output | N_CH | Generated waveforms |

## Verification
In clock mode, the durations tried are exact multiples of the tick and also non-multiples, which separates correct ceiling rounding from truncation. The range limit is probed at 6 and 7 to catch an off-by-one at the limit. In sync mode, the bench drives a phase that the time-of-day hits exactly, one that it steps over, and one reached only through the second rollover. A coarse time step later confirms that the crossing test does not rely on an exact match. The bench compares all four pins, running in mixed modes, against a behavioural model on every clock, so any coupling between pins shows up as a miscompare.

// File: rtl/wfg_pkg.sv
package wfg_pkg;

    localparam int NS_W = 30;
    localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;
    localparam logic [NS_W-1:0] MIN_DUR = 30'd6;

    typedef enum logic {
        ACT_IDLE  = 1'b0,
        ACT_CLOCK = 1'b1
    } wfg_act_e;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_CLK  = 2'd1,
        MODE_SYNC = 2'd2
    } wfg_mode_e;

    typedef struct packed {
        logic            act;
        logic            sync;
        logic [NS_W-1:0] hi;
        logic [NS_W-1:0] lo;
    } wfg_cfg_t;

    function automatic logic dur_ok(input logic [NS_W-1:0] d);
        return d > MIN_DUR;
    endfunction

    function automatic wfg_mode_e mode_of(input wfg_cfg_t c);
        wfg_mode_e m;
        m = MODE_OFF;
        if (c.act == ACT_CLOCK) begin
            if (c.sync) begin
                if (dur_ok(c.hi) && c.hi < NS_PER_SEC && c.lo < NS_PER_SEC)
                    m = MODE_SYNC;
            end else if (dur_ok(c.hi) && dur_ok(c.lo)) begin
                m = MODE_CLK;
            end
        end
        return m;
    endfunction

    // True when the phase lies in the half-open interval (prev, cur],
    // taking a rollover of the second into account.
    function automatic logic crossed(input logic [NS_W-1:0] prev,
                                     input logic [NS_W-1:0] cur,
                                     input logic [NS_W-1:0] phase);
        if (prev <= cur)
            return (phase > prev) && (phase <= cur);
        else
            return (phase > prev) || (phase <= cur);
    endfunction

endpackage

// File: rtl/wfg_tod_track.sv
module wfg_tod_track
    import wfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NS_W-1:0] tod_ns,
    output logic [NS_W-1:0] tod_prev,
    output logic            prev_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_prev <= '0;
            prev_ok  <= 1'b0;
        end else begin
            tod_prev <= tod_ns;
            prev_ok  <= 1'b1;
        end
    end

endmodule

// File: rtl/wfg_channel.sv
module wfg_channel
    import wfg_pkg::*;
#(
    parameter int TICK_NS = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  wfg_cfg_t        cfg,
    input  logic [NS_W-1:0] tod_ns,
    input  logic [NS_W-1:0] tod_prev,
    input  logic            prev_ok,
    output logic            pin_out
);

    localparam int CNT_W = NS_W + 1;
    localparam logic [CNT_W-1:0] STEP = CNT_W'(TICK_NS);

    wfg_mode_e        mode_d, mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             hit;
    logic [CNT_W-1:0] hi_x, lo_x;

    assign mode_d  = mode_of(cfg);
    assign hit     = prev_ok && crossed(tod_prev, tod_ns, cfg.lo);
    assign hi_x    = {1'b0, cfg.hi};
    assign lo_x    = {1'b0, cfg.lo};
    assign pin_out = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            unique case (mode_d)
                MODE_CLK: begin
                    if (mode_q != MODE_CLK) begin
                        out_q <= 1'b1;
                        cnt_q <= STEP;
                    end else if (cnt_q >= (out_q ? hi_x : lo_x)) begin
                        out_q <= ~out_q;
                        cnt_q <= STEP;
                    end else begin
                        cnt_q <= cnt_q + STEP;
                    end
                end
                MODE_SYNC: begin
                    if (hit) begin
                        out_q <= 1'b1;
                        cnt_q <= STEP;
                    end else if (mode_q != MODE_SYNC) begin
                        out_q <= 1'b0;
                        cnt_q <= '0;
                    end else if (out_q && cnt_q >= hi_x) begin
                        out_q <= 1'b0;
                    end else if (out_q) begin
                        cnt_q <= cnt_q + STEP;
                    end
                end
                default: begin
                    out_q <= 1'b0;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R1: reset leaves the pin low
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !pin_out);

    // R2: idle action drives the pin low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        (cfg.act == ACT_IDLE) |=> !pin_out);

    // R4: out-of-range clock settings keep the pin low
    a_r4_bad_clock_low: assert property (@(posedge clk) disable iff (rst)
        (cfg.act == ACT_CLOCK && !cfg.sync && (!dur_ok(cfg.hi) || !dur_ok(cfg.lo)))
        |=> !pin_out);

    // R3: entering clock mode raises the pin at once
    a_r3_enter_high: assert property (@(posedge clk) disable iff (rst)
        (mode_d == MODE_CLK && mode_q != MODE_CLK) |=> pin_out);

    // R5: a phase crossing in sync mode starts a pulse
    a_r5_sync_start: assert property (@(posedge clk) disable iff (rst)
        (mode_d == MODE_SYNC && hit) |=> pin_out);

    // R9: invalid sync settings keep the pin low
    a_r9_bad_sync_low: assert property (@(posedge clk) disable iff (rst)
        (cfg.act == ACT_CLOCK && cfg.sync && cfg.lo >= NS_PER_SEC) |=> !pin_out);

endmodule

// File: rtl/wfg_top.sv
module wfg_top
    import wfg_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int TICK_NS = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [29:0]                tod_ns,
    input  logic [N_CH-1:0]            cfg_act,
    input  logic [N_CH-1:0]            cfg_sync,
    input  logic [N_CH-1:0][29:0]      high_ns,
    input  logic [N_CH-1:0][29:0]      low_ns,
    output logic [N_CH-1:0]            pin_out
);

    logic [NS_W-1:0] tod_prev;
    logic            prev_ok;

    wfg_tod_track u_track (
        .clk      (clk),
        .rst      (rst),
        .tod_ns   (tod_ns),
        .tod_prev (tod_prev),
        .prev_ok  (prev_ok)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        wfg_cfg_t cfg_g;
        assign cfg_g = '{act: cfg_act[g], sync: cfg_sync[g], hi: high_ns[g], lo: low_ns[g]};

        wfg_channel #(.TICK_NS(TICK_NS)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg_g),
            .tod_ns   (tod_ns),
            .tod_prev (tod_prev),
            .prev_ok  (prev_ok),
            .pin_out  (pin_out[g])
        );
    end

endmodule

// File: tb/wfg_top_tb_top.sv
`timescale 1ns/1ps
module wfg_top_tb_top;

    localparam int N  = 4;
    localparam int TK = 20;
    localparam longint SEC = 64'd1_000_000_000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [29:0]       tod_ns = '0;
    logic [N-1:0]      cfg_act = '0;
    logic [N-1:0]      cfg_sync = '0;
    logic [N-1:0][29:0] high_ns = '0;
    logic [N-1:0][29:0] low_ns = '0;
    logic [N-1:0]      pin_out;

    int     n_vec = 0;
    int     n_bad = 0;
    int     tod_inc = TK;
    string  req_of [N];

    // behavioural reference state
    longint m_cnt [N];
    bit     m_out [N];
    int     m_mode [N];
    longint m_prev = 0;
    bit     m_prev_ok = 0;

    always #10 clk = ~clk;

    wfg_top #(.N_CH(N), .TICK_NS(TK)) dut_i (
        .clk(clk), .rst(rst), .tod_ns(tod_ns), .cfg_act(cfg_act),
        .cfg_sync(cfg_sync), .high_ns(high_ns), .low_ns(low_ns), .pin_out(pin_out)
    );

    function automatic int want_mode(int c);
        longint h, l;
        h = high_ns[c];
        l = low_ns[c];
        if (!cfg_act[c]) return 0;
        if (cfg_sync[c]) return (h > 6 && h < SEC && l < SEC) ? 2 : 0;
        return (h > 6 && l > 6) ? 1 : 0;
    endfunction

    function automatic bit passes(longint p, longint cur, longint ph);
        longint dc, dp;
        dc = (cur - p + SEC) % SEC;
        dp = (ph - p + SEC) % SEC;
        return (dp != 0) && (dp <= dc);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                m_cnt[c] = 0; m_out[c] = 0; m_mode[c] = 0;
            end
            m_prev = 0;
            m_prev_ok = 0;
        end else begin
            for (int c = 0; c < N; c++) begin
                int nm;
                bit go;
                nm = want_mode(c);
                go = m_prev_ok && passes(m_prev, tod_ns, low_ns[c]);
                if (nm == 1) begin
                    if (m_mode[c] != 1) begin m_out[c] = 1; m_cnt[c] = TK; end
                    else if (m_cnt[c] >= (m_out[c] ? longint'(high_ns[c]) : longint'(low_ns[c]))) begin
                        m_out[c] = !m_out[c]; m_cnt[c] = TK;
                    end else m_cnt[c] += TK;
                end else if (nm == 2) begin
                    if (go) begin m_out[c] = 1; m_cnt[c] = TK; end
                    else if (m_mode[c] != 2) begin m_out[c] = 0; m_cnt[c] = 0; end
                    else if (m_out[c] && m_cnt[c] >= longint'(high_ns[c])) m_out[c] = 0;
                    else if (m_out[c]) m_cnt[c] += TK;
                end else begin
                    m_out[c] = 0; m_cnt[c] = 0;
                end
                m_mode[c] = nm;
            end
            m_prev = tod_ns;
            m_prev_ok = 1;
        end
    end

    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            n_vec++;
            if (pin_out[c] !== m_out[c]) begin
                n_bad++;
                $display("FAIL %s pin %0d t=%0t actual=%b expected=%b",
                         req_of[c], c, $time, pin_out[c], m_out[c]);
            end
        end
        tod_ns = 30'((longint'(tod_ns) + tod_inc) % SEC);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_ch(int c, bit a, bit s, int h, int l, string r);
        cfg_act[c] = a; cfg_sync[c] = s;
        high_ns[c] = 30'(h); low_ns[c] = 30'(l);
        req_of[c] = r;
    endtask

    initial begin
        for (int c = 0; c < N; c++) req_of[c] = "R1";
        // R1: reset, with settings that would otherwise drive pins
        set_ch(0, 1, 0, 100, 100, "R1");
        run(4);
        rst = 1'b0;
        run(1);
        // R3 exact multiples, R3 rounding, R2 idle with values, R4 lower limit
        set_ch(0, 1, 0, 100, 60, "R3");
        set_ch(1, 1, 0, 30, 50, "R3");
        set_ch(2, 0, 1, 500, 40, "R2");
        set_ch(3, 1, 0, 6, 100, "R4");
        run(40);
        set_ch(3, 1, 0, 7, 7, "R4");
        run(20);
        set_ch(3, 1, 0, 100, 6, "R4");
        run(10);
        // R10: mixed modes on all pins at once
        set_ch(3, 1, 1, 200, 999_999_700, "R10");
        set_ch(2, 1, 0, 40, 80, "R10");
        tod_ns = 30'd999_999_000;
        run(60);
        // sync mode: R5 exact hit, R6 step across, R7 wrap, R9 bad phase
        set_ch(0, 1, 1, 1000, 999_999_500, "R5");
        set_ch(1, 1, 1, 500, 999_999_510, "R6");
        set_ch(2, 1, 1, 300, 0, "R7");
        set_ch(3, 1, 1, 300, 1_000_000_000, "R9");
        tod_ns = 30'd999_998_000;
        run(200);
        // R8: pulse length then low until next crossing
        set_ch(0, 1, 1, 130, 999_998_900, "R8");
        set_ch(3, 1, 1, 6, 999_998_900, "R9");
        tod_ns = 30'd999_998_000;
        run(120);
        // R6 with a coarse time step
        tod_inc = 200;
        set_ch(1, 1, 1, 400, 333_333_333, "R6");
        tod_ns = 30'd333_331_000;
        run(40);
        tod_inc = TK;
        // R2: idle after activity
        for (int c = 0; c < N; c++) set_ch(c, 0, c[0], 100, 100, "R2");
        run(10);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule